// File: doc/BRIEF.md
# Level-Sensitive Interrupt Combiner with Set/Clear Enables

This block collects level-sensitive interrupt request lines from peripherals and merges them into two processor-facing outputs: a normal interrupt line and a fast interrupt line. Each output has its own enable mask. Either output is high while at least one request it has enabled is active.

Software never rewrites a whole mask. For each mask there is one register that turns enables on and a second register that turns them off. Only the bits written as one are affected, so no read-modify-write is needed. Only the low 22 sources are implemented. The other enable bits stay zero and cannot be set.

The normal-interrupt mask can be read back. A driver can save it, disable everything, and later restore it through the enable-on register. A request is acknowledged by masking it or by having the peripheral drop it. Registers are reached through a single-cycle synchronous port: a write takes effect at the clock edge, and read data follows the address combinationally.

Top module: `lvl_intc`

## Requirements
- R1: While reset is asserted and after it is released, both enable masks are zero, and both `irq_o` and `fiq_o` are low regardless of `req`.
- R2: A write to word address 3 sets every normal-interrupt enable bit whose data bit is 1; enable bits written with 0 keep their value.
- R3: A write to word address 4 clears every normal-interrupt enable bit whose data bit is 1; writing all ones disables every source in one access.
- R4: Word addresses 7 (set) and 8 (clear) change the fast-interrupt mask with the same write-one semantics as R2 and R3; the two masks are independent.
- R5: Only sources 0 to 21 exist (mask 0x003FFFFF): enable bits 22 to 31 read as zero, ignore writes, and requests on lines 22 to 31 never raise either output or appear in any status word.
- R6: In the same cycle, `irq_o` is the OR of `req` AND the normal-interrupt mask, and `fiq_o` is the OR of `req` AND the fast-interrupt mask.
- R7: Reads return: address 0, the raw requests; 1, the requests masked by the normal-interrupt enables; 2, the normal-interrupt mask; 5, the requests masked by the fast-interrupt enables; 6, the fast-interrupt mask. The write-only and unmapped addresses read as zero.
- R8: Requests are levels. An output falls as soon as its enabled requests go low, or as soon as the request is masked through a clear write.
- R9: A write to a read-only or unmapped address, or any cycle with `bus_sel` low, leaves both masks unchanged.
- R10: Saving the mask read at address 2, clearing all enables, and writing the saved value to address 3 restores exactly the saved mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 32 | Level-sensitive request lines, one per source |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
The hardest case to reach is a request held high while its enable is being removed. The bench keeps a source asserted and issues a clear write to its mask. The output must fall in the cycle after the write, while the request line stays high and the same line still raises the other output through the other mask. Upper-line requests are driven with every enable bit written to one, which shows that no unimplemented source can reach either output.

// File: rtl/lvl_intc.sv
module lvl_intc #(
  parameter int          DW    = 32,
  parameter int          AW    = 4,
  parameter logic [DW-1:0] VALID = 32'h003F_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] req,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o,
  output logic          fiq_o
);
  localparam logic [AW-1:0] A_RAW    = AW'(0);
  localparam logic [AW-1:0] A_IRQST  = AW'(1);
  localparam logic [AW-1:0] A_IRQEN  = AW'(2);
  localparam logic [AW-1:0] A_IRQSET = AW'(3);
  localparam logic [AW-1:0] A_IRQCLR = AW'(4);
  localparam logic [AW-1:0] A_FIQST  = AW'(5);
  localparam logic [AW-1:0] A_FIQEN  = AW'(6);
  localparam logic [AW-1:0] A_FIQSET = AW'(7);
  localparam logic [AW-1:0] A_FIQCLR = AW'(8);

  logic [DW-1:0] irq_en, fiq_en;
  logic [DW-1:0] raw, irq_st, fiq_st;
  logic          wr;

  assign wr     = bus_sel & bus_wr;
  assign raw    = req & VALID;
  assign irq_st = raw & irq_en;
  assign fiq_st = raw & fiq_en;
  assign irq_o  = |irq_st;
  assign fiq_o  = |fiq_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= '0;
      fiq_en <= '0;
    end else if (wr) begin
      if (bus_addr == A_IRQSET) irq_en <= (irq_en | bus_wdata) & VALID;
      if (bus_addr == A_IRQCLR) irq_en <= irq_en & ~bus_wdata;
      if (bus_addr == A_FIQSET) fiq_en <= (fiq_en | bus_wdata) & VALID;
      if (bus_addr == A_FIQCLR) fiq_en <= fiq_en & ~bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_RAW:   bus_rdata = raw;
      A_IRQST: bus_rdata = irq_st;
      A_IRQEN: bus_rdata = irq_en;
      A_FIQST: bus_rdata = fiq_st;
      A_FIQEN: bus_rdata = fiq_en;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk #(
  parameter int          DW    = 32,
  parameter int          AW    = 4,
  parameter logic [DW-1:0] VALID = 32'h003F_FFFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] req,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] irq_en,
  input logic [DW-1:0] fiq_en,
  input logic          irq_o,
  input logic          fiq_o
);
  // R1
  reset_low_chk: assert property (@(posedge clk) !rst_n |-> !irq_o && !fiq_o);

  // R2
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_addr == AW'(3) |=>
      (irq_en & $past(bus_wdata & VALID)) == $past(bus_wdata & VALID)
      && (irq_en & ~$past(bus_wdata)) == ($past(irq_en) & ~$past(bus_wdata)));

  // R3
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_addr == AW'(4) |=> (irq_en & $past(bus_wdata)) == '0);

  // R4
  fiq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_addr == AW'(8) |=>
      (fiq_en & $past(bus_wdata)) == '0 && irq_en == $past(irq_en));

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_en | fiq_en) & ~VALID) == '0);

  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req & irq_en) == '0 |-> !irq_o);

  // R6
  fiq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req & fiq_en) == '0 |-> !fiq_o);

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> $stable(irq_en) && $stable(fiq_en));
endmodule

bind lvl_intc lvl_intc_chk #(.DW(DW), .AW(AW), .VALID(VALID)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_en(irq_en), .fiq_en(fiq_en),
  .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/test_lvl_intc.sv
module test_lvl_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lvl_intc i_lvl_intc (
    .clk(clk), .rst_n(rst_n), .req(req), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  typedef struct packed {
    logic [7:0]  rq;
    logic [31:0] rqin;
    logic [3:0]  wa;
    logic [31:0] wd;
    logic [3:0]  ra;
    logic [31:0] exp;
    logic        eirq;
    logic        efiq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{8'd2,  32'h0000_00FF, 4'h3, 32'h0000_000F, 4'h2, 32'h0000_000F, 1'b1, 1'b0}, // R2
    '{8'd2,  32'h0000_00FF, 4'h3, 32'h0000_0F00, 4'h2, 32'h0000_0F0F, 1'b1, 1'b0}, // R2 keep
    '{8'd3,  32'h0000_00FF, 4'h4, 32'h0000_0005, 4'h2, 32'h0000_0F0A, 1'b1, 1'b0}, // R3
    '{8'd7,  32'h0000_0F00, 4'hF, 32'h0000_0000, 4'h1, 32'h0000_0F00, 1'b1, 1'b0}, // R7 status
    '{8'd8,  32'h0000_0000, 4'hF, 32'h0000_0000, 4'h1, 32'h0000_0000, 1'b0, 1'b0}, // R8 level drop
    '{8'd5,  32'hFFFF_FFFF, 4'h3, 32'hFFFF_FFFF, 4'h2, 32'h003F_FFFF, 1'b1, 1'b0}, // R5
    '{8'd7,  32'hFFFF_FFFF, 4'hF, 32'h0000_0000, 4'h0, 32'h003F_FFFF, 1'b1, 1'b0}, // R7 raw
    '{8'd5,  32'hFFC0_0000, 4'hF, 32'h0000_0000, 4'h1, 32'h0000_0000, 1'b0, 1'b0}, // R5 upper lines
    '{8'd4,  32'hFFC0_0000, 4'h7, 32'hFFFF_FFFF, 4'h6, 32'h003F_FFFF, 1'b0, 1'b0}, // R4 set
    '{8'd8,  32'h0000_0100, 4'h8, 32'h0000_0100, 4'h6, 32'h003F_FEFF, 1'b1, 1'b0}, // R8 mask ack, R4 clear
    '{8'd3,  32'h0000_0100, 4'h4, 32'hFFFF_FFFF, 4'h2, 32'h0000_0000, 1'b0, 1'b0}, // R3 all ones
    '{8'd6,  32'h0000_0200, 4'hF, 32'h0000_0000, 4'h5, 32'h0000_0200, 1'b0, 1'b1}, // R6 fiq path
    '{8'd9,  32'h0000_0200, 4'h0, 32'hFFFF_FFFF, 4'h2, 32'h0000_0000, 1'b0, 1'b1}, // R9 read-only write
    '{8'd7,  32'h0000_0200, 4'h8, 32'hFFFF_FFFF, 4'h3, 32'h0000_0000, 1'b0, 1'b0}  // R7 write-only reads 0
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_op(input logic sel, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_op(input logic [3:0] a);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] saved;
    req = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    rd_op(4'h2);
    check("R1 irq mask in reset", bus_rdata, 32'h0);
    check("R1 outputs in reset", {30'h0, irq_o, fiq_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_op(4'h6);
    check("R1 fiq mask after reset", bus_rdata, 32'h0);
    check("R1 outputs after reset", {30'h0, irq_o, fiq_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req = VEC[i].rqin;
      wr_op(1'b1, VEC[i].wa, VEC[i].wd);
      rd_op(VEC[i].ra);
      check($sformatf("R%0d vector %0d rdata", VEC[i].rq, i), bus_rdata, VEC[i].exp);
      check($sformatf("R6 vector %0d outputs", i), {30'h0, irq_o, fiq_o},
            {30'h0, VEC[i].eirq, VEC[i].efiq});
    end

    // R9: bus_sel low blocks a write
    req = 32'h0000_0001;
    wr_op(1'b0, 4'h3, 32'h0000_0001);
    rd_op(4'h2);
    check("R9 unselected write", bus_rdata, 32'h0);
    check("R9 irq stays low", {31'h0, irq_o}, 32'h0);

    // R10: save and restore
    wr_op(1'b1, 4'h3, 32'h0012_3456);
    rd_op(4'h2);
    saved = bus_rdata;
    check("R10 saved mask", saved, 32'h0012_3456);
    wr_op(1'b1, 4'h4, 32'hFFFF_FFFF);
    rd_op(4'h2);
    check("R10 cleared", bus_rdata, 32'h0);
    wr_op(1'b1, 4'h3, saved);
    rd_op(4'h2);
    check("R10 restored", bus_rdata, 32'h0012_3456);

    // R4: fiq mask independent of irq mask
    rd_op(4'h6);
    check("R4 fiq mask untouched", bus_rdata, 32'h0);

    // R1: reset mid-run clears masks
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    rd_op(4'h2);
    check("R1 mid-run reset", bus_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule